// File: doc/BRIEF.md
# Ping-Pong Divider Setting Register File

This block holds the programmed divide settings of a frequency synthesizer and loads them from an 8-bit parallel bus. There are five write strobes. Three of them land bus data in sections of a working (primary) copy of the divider setting: the low main-divider byte, the high main-divider bit, and the swallow count. A fourth strobe, the hop strobe, copies the whole working copy into a standby (secondary) copy. The fifth strobe loads an 8-bit enhancement control byte. The strobes come from outside the clock domain, so each one passes through a synchronizer and a small rising-edge state machine before it acts.

A live select input chooses which copy drives the divider outputs. Software can therefore preload one setting while the loop runs on the other, and then switch between them at once. The enhancement byte reaches its output only while an active-low gate input is asserted; otherwise the output is zero. Writes of all kinds are accepted only in parallel programming mode, which means both mode inputs are low.

Each strobe has its own edge state machine with two states. `ES_IDLE_LOW` waits for the synchronized strobe to go high. The transition `arm` (synchronized strobe high) moves to `ES_HELD_HIGH` and emits one write pulse in the same cycle. The transition `release` (synchronized strobe low) returns to `ES_IDLE_LOW`. In either state, when the synchronized level does not change, the machine holds its state and emits no pulse.

Top module: `divset_pingpong_regs`

## Requirements
- R1: Reset clears the working copy, the standby copy and the enhancement byte, so `m_ratio`, `a_ratio` and `enh_ctl` read 0 whatever `use_primary` is.
- R2: A rising edge on `stb_m_lo` loads `bus_d[7:0]` into main-divider bits [7:0] of the working copy.
- R3: A rising edge on `stb_m_hi` loads `bus_d[0]` into main-divider bit 8 of the working copy. `bus_d[7:1]` is ignored, and those positions have no storage.
- R4: A rising edge on `stb_a` loads `bus_d[3:0]` into the 4-bit swallow count of the working copy. `bus_d[7:4]` is ignored.
- R5: When `use_primary` is 1, `m_ratio` and `a_ratio` show the working copy. When it is 0, they show the standby copy.
- R6: A rising edge on `stb_hop` copies the whole working copy (main divider and swallow count) into the standby copy.
- R7: If a hop pulse and a section write pulse fall in the same cycle, the standby copy receives the working copy as it was before that write, and the working copy takes the new data.
- R8: A rising edge on `stb_enh` loads `bus_d` into the enhancement byte. `enh_ctl` shows that byte while `enh_gate_n` is 0 and shows 0 while it is 1.
- R9: Strobe edges have no effect unless `pgm_mode0` and `pgm_mode1` are both 0.
- R10: A strobe writes once per rising edge. Holding it high while the bus changes does not write again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pgm_mode0 | input | 1 | Mode select bit 0; parallel mode when both mode bits are 0 |
| pgm_mode1 | input | 1 | Mode select bit 1 |
| bus_d | input | 8 | Parallel programming data |
| stb_m_lo | input | 1 | Write strobe, main-divider low byte |
| stb_m_hi | input | 1 | Write strobe, main-divider bit 8 |
| stb_a | input | 1 | Write strobe, swallow count |
| stb_hop | input | 1 | Copy working copy to standby copy |
| stb_enh | input | 1 | Write strobe, enhancement byte |
| use_primary | input | 1 | 1 selects the working copy, 0 the standby copy |
| enh_gate_n | input | 1 | Active-low enable for the enhancement byte |
| m_ratio | output | 9 | Selected main-divider value |
| a_ratio | output | 4 | Selected swallow count |
| enh_ctl | output | 8 | Gated enhancement byte |

## Verification
Four section patterns are written: all zeros with only the high bit set, all ones, alternating bits, and the inverted alternation. Each pattern is read through both copies, which tells apart a wrong section mapping, leakage from unused bus bits, and a hop that copies only part of the setting. Directed cases then drive a hop together with a low-byte write in the same cycle, strobes sent in each non-parallel mode, a strobe held high while the bus changes, and the enhancement byte with its gate in both states. Together these show old-versus-new ordering, mode gating, single-write edge behaviour and gating to zero.

// File: rtl/dreg_pkg.sv
package dreg_pkg;
    localparam int BUS_W = 8;
    localparam int M_W   = 9;
    localparam int A_W   = 4;
    localparam int HI_W  = M_W - BUS_W;
    localparam int N_STB = 5;

    // strobe index map
    localparam int IX_MLO = 0;
    localparam int IX_MHI = 1;
    localparam int IX_A   = 2;
    localparam int IX_HOP = 3;
    localparam int IX_ENH = 4;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
    } div_set_t;

    typedef enum logic {
        ES_IDLE_LOW,
        ES_HELD_HIGH
    } edge_state_t;
endpackage

// File: rtl/dreg_strobe_edge.sv
module dreg_strobe_edge
    import dreg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic rise_pulse
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    edge_state_t       state_q;
    edge_state_t       state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], strobe_in};
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ES_IDLE_LOW;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ES_IDLE_LOW:  if (sync_q[TOP])  state_d = ES_HELD_HIGH; // arm
            ES_HELD_HIGH: if (!sync_q[TOP]) state_d = ES_IDLE_LOW;  // release
            default:      state_d = ES_IDLE_LOW;
        endcase
    end

    // outputs
    always_comb begin
        rise_pulse = 1'b0;
        unique case (state_q)
            ES_IDLE_LOW:  rise_pulse = sync_q[TOP];
            ES_HELD_HIGH: rise_pulse = 1'b0;
            default:      rise_pulse = 1'b0;
        endcase
    end

    // R10: one pulse per rising edge
    a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/dreg_div_bank.sv
module dreg_div_bank
    import dreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             wr_a,
    input  logic             hop,
    input  logic             sel_primary,
    output div_set_t         live_set
);
    div_set_t pri_q;
    div_set_t sec_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_q <= '0;
            sec_q <= '0;
        end else begin
            if (wr_lo) pri_q.m[BUS_W-1:0]   <= wr_data;
            if (wr_hi) pri_q.m[M_W-1:BUS_W] <= wr_data[HI_W-1:0];
            if (wr_a)  pri_q.a              <= wr_data[A_W-1:0];
            if (hop)   sec_q                <= pri_q;  // pre-write contents
        end
    end

    always_comb live_set = sel_primary ? pri_q : sec_q;

    a_r2_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> pri_q.m[BUS_W-1:0] == $past(wr_data));
    a_r6_hop_copy: assert property (@(posedge clk) disable iff (!rst_n)
        hop |=> sec_q == $past(pri_q));
    a_r7_old_on_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (hop && (wr_lo || wr_hi || wr_a)) |=> sec_q == $past(pri_q));
    a_r9_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lo || wr_hi || wr_a || hop) |=> ($stable(pri_q) && $stable(sec_q)));
endmodule

// File: rtl/divset_pingpong_regs.sv
module divset_pingpong_regs
    import dreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pgm_mode0,
    input  logic             pgm_mode1,
    input  logic [BUS_W-1:0] bus_d,
    input  logic             stb_m_lo,
    input  logic             stb_m_hi,
    input  logic             stb_a,
    input  logic             stb_hop,
    input  logic             stb_enh,
    input  logic             use_primary,
    input  logic             enh_gate_n,
    output logic [M_W-1:0]   m_ratio,
    output logic [A_W-1:0]   a_ratio,
    output logic [BUS_W-1:0] enh_ctl
);
    logic [N_STB-1:0] raw_stb;
    logic [N_STB-1:0] rise;
    logic [N_STB-1:0] wr_go;
    logic             par_mode;
    logic [BUS_W-1:0] enh_q;
    div_set_t         live_set;

    assign raw_stb = {stb_enh, stb_hop, stb_a, stb_m_hi, stb_m_lo};
    assign par_mode = !pgm_mode0 && !pgm_mode1;
    assign wr_go = rise & {N_STB{par_mode}};

    for (genvar gi = 0; gi < N_STB; gi++) begin : g_edge
        dreg_strobe_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk        (clk),
            .rst_n      (rst_n),
            .strobe_in  (raw_stb[gi]),
            .rise_pulse (rise[gi])
        );
    end

    dreg_div_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_data     (bus_d),
        .wr_lo       (wr_go[IX_MLO]),
        .wr_hi       (wr_go[IX_MHI]),
        .wr_a        (wr_go[IX_A]),
        .hop         (wr_go[IX_HOP]),
        .sel_primary (use_primary),
        .live_set    (live_set)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)             enh_q <= '0;
        else if (wr_go[IX_ENH]) enh_q <= bus_d;
    end

    always_comb begin
        m_ratio = live_set.m;
        a_ratio = live_set.a;
        enh_ctl = enh_gate_n ? '0 : enh_q;
    end

    a_r9_enh_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_mode0 || pgm_mode1) |=> $stable(enh_q));
    a_r8_enh_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go[IX_ENH] |=> enh_q == $past(bus_d));
endmodule

// File: tb/divset_pingpong_regs_bench.sv
`timescale 1ns/1ps
module divset_pingpong_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pgm_mode0 = 1'b0, pgm_mode1 = 1'b0;
    logic [7:0] bus_d = '0;
    logic [4:0] stb = '0; // 0 mlo,1 mhi,2 a,3 hop,4 enh
    logic       use_primary = 1'b1;
    logic       enh_gate_n = 1'b0;
    logic [8:0] m_ratio;
    logic [3:0] a_ratio;
    logic [7:0] enh_ctl;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    divset_pingpong_regs u_divset_pingpong_regs (
        .clk(clk), .rst_n(rst_n), .pgm_mode0(pgm_mode0), .pgm_mode1(pgm_mode1),
        .bus_d(bus_d), .stb_m_lo(stb[0]), .stb_m_hi(stb[1]), .stb_a(stb[2]),
        .stb_hop(stb[3]), .stb_enh(stb[4]), .use_primary(use_primary),
        .enh_gate_n(enh_gate_n), .m_ratio(m_ratio), .a_ratio(a_ratio),
        .enh_ctl(enh_ctl)
    );

    localparam int NV = 4;
    localparam logic [7:0] V_LO [NV] = '{8'h00, 8'hFF, 8'h5A, 8'hA5};
    localparam logic [7:0] V_HI [NV] = '{8'h01, 8'hFE, 8'hFF, 8'h00};
    localparam logic [7:0] V_A  [NV] = '{8'h0A, 8'hF3, 8'h1F, 8'h07};
    localparam logic [8:0] V_EM [NV] = '{9'h100, 9'h0FF, 9'h15A, 9'h0A5};
    localparam logic [3:0] V_EA [NV] = '{4'hA, 4'h3, 4'hF, 4'h7};

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic strobe(input int idx, input logic [7:0] d);
        @(negedge clk);
        bus_d = d;
        stb[idx] = 1'b1;
        repeat (4) @(negedge clk);
        stb[idx] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic view(input logic prim);
        @(negedge clk);
        use_primary = prim;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        view(1'b1);
        check("R1 m primary", m_ratio, 0);
        check("R1 a primary", a_ratio, 0);
        check("R1 enh", enh_ctl, 0);
        view(1'b0);
        check("R1 m standby", m_ratio, 0);

        for (int i = 0; i < NV; i++) begin
            strobe(0, V_LO[i]);
            strobe(1, V_HI[i]);
            strobe(2, V_A[i]);
            view(1'b1);
            check("R2/R3 m primary", m_ratio, V_EM[i]);
            check("R4 a primary", a_ratio, V_EA[i]);
            strobe(3, 8'h00);
            view(1'b0);
            check("R6 m standby", m_ratio, V_EM[i]);
            check("R5 R6 a standby", a_ratio, V_EA[i]);
        end

        // R7: hop together with low-byte write
        strobe(0, 8'h33);
        @(negedge clk);
        bus_d = 8'h44;
        stb[0] = 1'b1;
        stb[3] = 1'b1;
        repeat (4) @(negedge clk);
        stb = '0;
        repeat (4) @(negedge clk);
        view(1'b0);
        check("R7 standby old", m_ratio, 9'h033);
        view(1'b1);
        check("R7 primary new", m_ratio, 9'h044);

        // R9: writes ignored outside parallel mode
        pgm_mode0 = 1'b1;
        strobe(0, 8'h99);
        strobe(4, 8'hEE);
        pgm_mode0 = 1'b0;
        pgm_mode1 = 1'b1;
        strobe(3, 8'h00);
        strobe(2, 8'h0C);
        pgm_mode1 = 1'b0;
        view(1'b1);
        check("R9 primary m kept", m_ratio, 9'h044);
        check("R9 primary a kept", a_ratio, 4'h7);
        view(1'b0);
        check("R9 standby kept", m_ratio, 9'h033);
        check("R9 enh kept", enh_ctl, 0);

        // R10: one write per held strobe
        @(negedge clk);
        bus_d = 8'h12;
        stb[0] = 1'b1;
        repeat (6) @(negedge clk);
        bus_d = 8'h34;
        repeat (6) @(negedge clk);
        stb[0] = 1'b0;
        repeat (4) @(negedge clk);
        view(1'b1);
        check("R10 single write", m_ratio, 9'h012);

        // R8: enhancement byte and gate
        strobe(4, 8'hC3);
        enh_gate_n = 1'b0;
        #1;
        check("R8 enh visible", enh_ctl, 8'hC3);
        @(negedge clk);
        enh_gate_n = 1'b1;
        #1;
        check("R8 enh gated", enh_ctl, 0);

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        enh_gate_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        view(1'b1);
        check("R1 m after reset", m_ratio, 0);
        check("R1 enh after reset", enh_ctl, 0);
        view(1'b0);
        check("R1 standby after reset", m_ratio, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule